// File: doc/BRIEF.md
# Clear-on-Read MAC Event Statistics Bank

This block keeps two 8-bit event tallies for an Ethernet MAC transmit path: one for late collisions and one for frames whose deferral ran past the limit. The MAC core feeds single-cycle late-collision pulses. For deferral it supplies a level that stays high while deferral is excessive, plus a per-frame start strobe. The block turns that level into at most one count per frame.

Software reaches the block through a small register bus with combinational read data. Reading a tally returns its value and zeroes it in the same cycle. Counting runs only while a global statistics enable is set. A tally wraps modulo 256.

When either tally steps into 0xC0, a sticky status bit is set. Software clears that bit by writing 1 to it. A level interrupt output is driven while the status bit is set and its mask bit is on.

Top module: `stat_ctr_bank`

## Requirements
- R1: After reset both tallies read 0x00, the control register reads 0x00, the status register reads 0x00, the mask register reads 0x00 and `irq` is 0.
- R2: While enabled, each cycle with `late_col_evt` high adds exactly one to the late-collision tally.
- R3: A tally at 0xFF becomes 0x00 on its next counted event.
- R4: The statistics enable is bit 0 of the control register at offset 0x70, and it reads back as written. While it is 0, events leave both tallies unchanged.
- R5: A read returns the tally and clears it. The late-collision tally is at offset 0x75 and the deferral tally is at offset 0x7A. Reads of unmapped offsets (for example 0x74) return 0.
- R6: If a counted event and a read of the same tally fall in one cycle, the read returns the value from before the event and the tally holds 1 afterwards.
- R7: Bit 0 of the status register at offset 0x72 is set in the cycle after either tally steps from 0xBF to 0xC0.
- R8: The status bit is cleared by writing 1 to bit 0 of offset 0x72. A new threshold crossing in the same cycle wins over the clear. A tally that simply stays at 0xC0 does not set the bit again.
- R9: `irq` is high exactly while the status bit and bit 0 of the mask register at offset 0x73 are both 1.
- R10: The deferral tally counts once per frame. A `defer_over` level held over many cycles counts once, and a new count needs a `frame_start` strobe first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read-clear takes effect at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 0 when not reading |
| late_col_evt | input | 1 | Late collision pulse from MAC |
| defer_over | input | 1 | Deferral-limit-exceeded level from MAC |
| frame_start | input | 1 | New transmit frame strobe, rearms deferral counting |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps event counts from 0 through 260 on the late-collision tally and through 200 on the deferral tally. Each count is checked arithmetically, and so is whether the status bit should be set. A design that saturates instead of wrapping, fires on overflow, or fires one count early fails these checks.

A read coinciding with an event is checked for both the returned value and the value left behind. A design that lets the clear swallow the event reads back 0 here.

Other checks cover a tally left at 0xC0 after the status is cleared, and a clear colliding with a new crossing. They also cover a deferral level held across a frame boundary. A design that compares levels instead of transitions, or counts every cycle of deferral, would show too many counts or a reasserted status bit.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int NUM_CTR = 2;
  localparam logic [7:0] OFF_CTRL  = 8'h70;
  localparam logic [7:0] OFF_ISR   = 8'h72;
  localparam logic [7:0] OFF_IMR   = 8'h73;
  localparam logic [7:0] OFF_LATE  = 8'h75;
  localparam logic [7:0] OFF_DEFER = 8'h7A;

  // Index 0: late collisions, index 1: excessive deferral
  function automatic logic [7:0] ctr_offset(input int idx);
    return (idx == 0) ? OFF_LATE : OFF_DEFER;
  endfunction
endpackage

// File: rtl/defer_gate.sv
module defer_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic defer_over,
  input  logic frame_start,
  output logic defer_pulse
);
  logic armed;

  assign defer_pulse = defer_over & armed;

  always_ff @(posedge clk) begin
    if (!rst_n)           armed <= 1'b1;
    else if (frame_start) armed <= 1'b1;
    else if (defer_pulse) armed <= 1'b0;
  end

  AST_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    defer_pulse && !frame_start |=> !defer_pulse); // R10
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] THRESH = W'(8'hC0)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         thresh_hit
);
  // Clear takes priority but an event in the same cycle survives it
  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic inc, input logic rc);
    if (rc) return inc ? W'(1) : '0;
    return inc ? cur + W'(1) : cur;
  endfunction

  logic         inc;
  logic [W-1:0] nxt;

  assign inc        = en & evt;
  assign nxt        = step(count, inc, clr);
  assign thresh_hit = inc & ~clr & (nxt == THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    en && evt && !clr && (count == {W{1'b1}}) |=> count == '0); // R3
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(en && evt) |=> count == '0); // R5
  AST_CLEAR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    clr && en && evt |=> count == W'(1)); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !clr |=> $stable(count)); // R4
endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
  import stat_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] THRESH = W'(8'hC0)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         late_col_evt,
  input  logic         defer_over,
  input  logic         frame_start,
  output logic         irq
);
  logic               stats_en;
  logic               irq_mask;
  logic               upd_stat;
  logic               defer_pulse;
  logic [NUM_CTR-1:0] evt_vec;
  logic [NUM_CTR-1:0] clr_vec;
  logic [NUM_CTR-1:0] hit_vec;
  logic [W-1:0]       cnt [NUM_CTR];
  logic               any_hit;
  logic               isr_wr_clr;

  defer_gate u_defer (
    .clk(clk), .rst_n(rst_n), .defer_over(defer_over),
    .frame_start(frame_start), .defer_pulse(defer_pulse)
  );

  assign evt_vec = {defer_pulse, late_col_evt};

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign clr_vec[i] = bus_rd && (bus_addr == ctr_offset(i));
    stat_counter #(.W(W), .THRESH(THRESH)) u_ctr (
      .clk(clk), .rst_n(rst_n), .en(stats_en), .evt(evt_vec[i]),
      .clr(clr_vec[i]), .count(cnt[i]), .thresh_hit(hit_vec[i])
    );
  end

  assign any_hit    = |hit_vec;
  assign isr_wr_clr = bus_wr && (bus_addr == OFF_ISR) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stats_en <= 1'b0;
      irq_mask <= 1'b0;
      upd_stat <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_CTRL) stats_en <= bus_wdata[0];
      if (bus_wr && bus_addr == OFF_IMR)  irq_mask <= bus_wdata[0];
      if (any_hit)         upd_stat <= 1'b1;
      else if (isr_wr_clr) upd_stat <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFF_CTRL:  bus_rdata = W'(stats_en);
        OFF_ISR:   bus_rdata = W'(upd_stat);
        OFF_IMR:   bus_rdata = W'(irq_mask);
        OFF_LATE:  bus_rdata = cnt[0];
        OFF_DEFER: bus_rdata = cnt[1];
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq = upd_stat & irq_mask;

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> upd_stat); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stat && !isr_wr_clr |=> upd_stat); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_stat) && irq_mask |-> irq); // R9
endmodule

// File: tb/stat_ctr_bank_bench.sv
module stat_ctr_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       late_col_evt = 1'b0;
  logic       defer_over = 1'b0;
  logic       frame_start = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stat_ctr_bank u_stat_ctr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .late_col_evt(late_col_evt), .defer_over(defer_over),
    .frame_start(frame_start), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic late_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); late_col_evt = 1'b1;
    end
    @(negedge clk); late_col_evt = 1'b0;
  endtask

  task automatic defer_frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); defer_over = 1'b1; frame_start = 1'b1;
    end
    @(negedge clk); defer_over = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h75, v); chk("R1 late", v, 0);
    rd(8'h7A, v); chk("R1 defer", v, 0);
    rd(8'h70, v); chk("R1 ctrl", v, 0);
    rd(8'h72, v); chk("R1 status", v, 0);
    rd(8'h73, v); chk("R1 mask", v, 0);
    chk("R1 irq", int'(irq), 0);
    // R4 disabled
    late_pulses(5); defer_frames(4);
    rd(8'h75, v); chk("R4 late disabled", v, 0);
    rd(8'h7A, v); chk("R4 defer disabled", v, 0);
    wr(8'h70, 8'h01);
    rd(8'h70, v); chk("R4 ctrl readback", v, 1);
    // R5 unmapped
    late_pulses(2);
    rd(8'h74, v); chk("R5 unmapped", v, 0);
    rd(8'h75, v); chk("R5 late value", v, 2);
    // R2 R3 R7 sweep on late-collision tally
    for (int n = 0; n <= 260; n++) begin
      wr(8'h72, 8'h01);
      late_pulses(n);
      rd(8'h72, v); chk("R7 late sweep status", v, (n >= 192) ? 1 : 0);
      rd(8'h75, v); chk("R2 R3 late sweep count", v, n % 256);
      rd(8'h75, v); chk("R5 late cleared", v, 0);
    end
    // R10 sweep on deferral tally, one frame per event
    for (int n = 0; n <= 200; n += 8) begin
      wr(8'h72, 8'h01);
      defer_frames(n);
      rd(8'h72, v); chk("R7 defer sweep status", v, (n >= 192) ? 1 : 0);
      rd(8'h7A, v); chk("R10 defer sweep count", v, n);
    end
    wr(8'h72, 8'h01);
    // R6 event with read
    late_pulses(3);
    @(negedge clk); bus_addr = 8'h75; bus_rd = 1'b1; late_col_evt = 1'b1;
    #1 v = int'(bus_rdata);
    chk("R6 read returns old", v, 3);
    @(negedge clk); bus_rd = 1'b0; late_col_evt = 1'b0;
    rd(8'h75, v); chk("R6 counter after", v, 1);
    // R9 R8 threshold behaviour
    late_pulses(192);
    rd(8'h72, v); chk("R7 at C0", v, 1);
    chk("R9 irq masked", int'(irq), 0);
    wr(8'h73, 8'h01);
    #1 chk("R9 irq unmasked", int'(irq), 1);
    wr(8'h70, 8'h00);
    wr(8'h72, 8'h01);
    #1 chk("R8 status cleared irq", int'(irq), 0);
    late_pulses(3);
    rd(8'h72, v); chk("R8 no reassert at C0", v, 0);
    rd(8'h75, v); chk("R4 held at C0", v, 8'hC0);
    // R8 set wins over clear
    wr(8'h70, 8'h01);
    late_pulses(191);
    @(negedge clk); late_col_evt = 1'b1;
    bus_addr = 8'h72; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk); late_col_evt = 1'b0; bus_wr = 1'b0;
    rd(8'h72, v); chk("R8 set wins", v, 1);
    chk("R9 irq set", int'(irq), 1);
    rd(8'h75, v); chk("R8 count C0", v, 8'hC0);
    // R10 held deferral level across a frame boundary
    @(negedge clk); defer_over = 1'b1;
    repeat (10) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    repeat (5) @(negedge clk);
    defer_over = 1'b0;
    rd(8'h7A, v); chk("R10 held level", v, 2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule